// File: doc/BRIEF.md
# Coalesced Tick Acknowledge Tracker

This block keeps track of outstanding end-of-interrupt (EOI) acknowledgements for a single edge-triggered interrupt line, typically a periodic timer tick, that fans out to up to `N` destination processors. Each time the tick is handed out, the block stores which destinations took it and, per destination, the vector it was delivered with, and loads a count of acknowledgements still owed. While that count is non-zero, a fresh edge on the line is flagged as coalesced so the surrounding logic can drop it instead of delivering it again. Routing the interrupt to the processors happens elsewhere.

Acknowledgements arrive as EOI events naming a processor and a vector; only a processor whose record bit is set and whose stored vector matches retires one. A clear command wipes the record. A rebuild command, or any attempt to take the count below zero, rebuilds the record from a live per-processor "EOI still owed" input. A per-processor resync compares one processor's live status with its record bit and repairs only a mismatch.

All events are single-cycle strobes that are always taken; there is no back-pressure. Only one event acts per cycle, chosen by a fixed priority, and lower-priority strobes in that cycle are dropped. A delivery offered while acknowledgements are still owed is refused and reported on an error pulse.

Top module: `tick_ack_tracker`

## Requirements
- R1: `coalesced_o` is combinational and is 1 exactly when `line_rise_i` is 1 and the pending count is non-zero.
- R2: A delivery taken while the count is zero sets the record bitmap to `dlv_map_i`, stores `dlv_vec_i` as the vector of every destination whose bit is set, and loads the count from `dlv_cnt_i`; the outputs show this one cycle later.
- R3: `dlv_cnt_i` is two's complement with its top bit as sign; a negative value (delivery failed) loads a count of zero.
- R4: A delivery offered while the count is non-zero changes neither bitmap nor count, and `dlv_err_o` is 1 for the following cycle only.
- R5: An EOI naming processor `eoi_id_i` whose bit is set and whose stored vector equals `eoi_vec_i` clears that bit and decrements the count by one.
- R6: An EOI whose processor bit is clear, or whose vector differs from the stored one, changes nothing.
- R7: A clear command, and the reset, set both count and bitmap to zero.
- R8: A rebuild command sets the bitmap to `proc_pend_i`, the count to the number of ones in `proc_pend_i`, and the stored vector of each set bit to `cfg_vec_i`.
- R9: An EOI or resync that would decrement a zero count instead performs the rebuild of R8.
- R10: A resync of processor `rs_id_i` whose live bit in `proc_pend_i` differs from its record bit copies the live bit, storing `cfg_vec_i` and incrementing the count when it sets, decrementing when it clears; when they agree nothing changes.
- R11: At most one event acts per cycle, in the priority clear, rebuild, delivery, EOI, resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear record and count |
| rebuild_i | input | 1 | Rebuild record from live pending status |
| line_rise_i | input | 1 | New edge seen on the tracked line |
| coalesced_o | output | 1 | The current edge is coalesced |
| dlv_valid_i | input | 1 | Delivery event strobe |
| dlv_map_i | input | N | Destinations that accepted the delivery |
| dlv_vec_i | input | VW | Vector used for the delivery |
| dlv_cnt_i | input | CW+1 | Signed accepted count, negative on failure |
| dlv_err_o | output | 1 | Delivery refused because acknowledgements are owed |
| eoi_valid_i | input | 1 | EOI event strobe |
| eoi_id_i | input | IDW | Processor issuing the EOI |
| eoi_vec_i | input | VW | Vector carried by the EOI |
| rs_valid_i | input | 1 | Per-processor resync strobe |
| rs_id_i | input | IDW | Processor to resync |
| cfg_vec_i | input | VW | Vector currently configured for the line |
| proc_pend_i | input | N | Live per-processor EOI-owed status |
| pend_cnt_o | output | CW | Acknowledgements still owed |
| map_o | output | N | Record bitmap |

## Verification
Deliveries are tried with several bitmaps and with positive, zero and negative counts, so a count loaded from the bitmap instead of the input, or a missing clamp, shows up. EOIs are sent with matching vectors, wrong vectors and to processors never recorded, which separates a vector-checked retire from a bit-only one. A count deliberately smaller than the bitmap drives the underflow rebuild, and resyncs in both directions plus an agreeing resync tell apart a repair from an unconditional copy. Same-cycle collisions of events and a long mixed random sequence against a reference model check the priority order.

// File: rtl/tat_pkg.sv
package tat_pkg;
  // event selected for the current cycle
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLR,
    OP_REBUILD,
    OP_DLV,
    OP_EOI,
    OP_RSYNC
  } tat_op_e;
endpackage

// File: rtl/tat_opsel.sv
module tat_opsel
  import tat_pkg::*;
(
  input  logic    clr_i,
  input  logic    rebuild_i,
  input  logic    dlv_valid_i,
  input  logic    eoi_valid_i,
  input  logic    rs_valid_i,
  output tat_op_e op_o
);
  // fixed priority: clear, rebuild, delivery, eoi, resync
  always_comb begin
    if (clr_i)            op_o = OP_CLR;
    else if (rebuild_i)   op_o = OP_REBUILD;
    else if (dlv_valid_i) op_o = OP_DLV;
    else if (eoi_valid_i) op_o = OP_EOI;
    else if (rs_valid_i)  op_o = OP_RSYNC;
    else                  op_o = OP_IDLE;
  end
endmodule

// File: rtl/tat_slot.sv
module tat_slot
  import tat_pkg::*;
#(
  parameter int VW  = 8,
  parameter int IDW = 3,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tat_op_e       op_i,
  input  logic          rebuild_all_i,
  input  logic          dlv_ok_i,
  input  logic          dlv_bit_i,
  input  logic [VW-1:0] dlv_vec_i,
  input  logic [IDW-1:0] eoi_id_i,
  input  logic [VW-1:0] eoi_vec_i,
  input  logic [IDW-1:0] rs_id_i,
  input  logic [VW-1:0] cfg_vec_i,
  input  logic          pend_bit_i,
  output logic          bit_o,
  output logic          eoi_hit_o,
  output logic          rs_diff_o
);
  localparam logic [IDW-1:0] MY_ID = IDW'(IDX);

  logic          rec_q;
  logic [VW-1:0] vec_q;

  assign bit_o     = rec_q;
  assign eoi_hit_o = (op_i == OP_EOI) && (eoi_id_i == MY_ID) && rec_q && (vec_q == eoi_vec_i);
  assign rs_diff_o = (op_i == OP_RSYNC) && (rs_id_i == MY_ID) && (pend_bit_i != rec_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= 1'b0;
      vec_q <= '0;
    end else if (op_i == OP_CLR) begin
      rec_q <= 1'b0;
    end else if (rebuild_all_i) begin
      rec_q <= pend_bit_i;
      if (pend_bit_i) vec_q <= cfg_vec_i;
    end else if (dlv_ok_i) begin
      rec_q <= dlv_bit_i;
      if (dlv_bit_i) vec_q <= dlv_vec_i;
    end else if (eoi_hit_o) begin
      rec_q <= 1'b0;
    end else if (rs_diff_o) begin
      rec_q <= pend_bit_i;
      if (pend_bit_i) vec_q <= cfg_vec_i;
    end
  end
endmodule

// File: rtl/tat_count.sv
module tat_count #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rebuild_i,
  input  logic [N-1:0]  pend_vec_i,
  input  logic          load_i,
  input  logic [CW:0]   load_val_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] pop;
  logic [CW-1:0] cnt_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N; i++) pop = pop + CW'(pend_vec_i[i]);
  end

  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (rebuild_i)  cnt_q <= pop;
    else if (load_i)     cnt_q <= load_val_i[CW] ? '0 : load_val_i[CW-1:0];
    else if (inc_i)      cnt_q <= cnt_q + 1'b1;
    else if (dec_i)      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tick_ack_tracker.sv
module tick_ack_tracker
  import tat_pkg::*;
#(
  parameter int  N   = 8,
  parameter int  VW  = 8,
  localparam int CW  = $clog2(N + 1),
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           rebuild_i,
  input  logic           line_rise_i,
  output logic           coalesced_o,
  input  logic           dlv_valid_i,
  input  logic [N-1:0]   dlv_map_i,
  input  logic [VW-1:0]  dlv_vec_i,
  input  logic [CW:0]    dlv_cnt_i,
  output logic           dlv_err_o,
  input  logic           eoi_valid_i,
  input  logic [IDW-1:0] eoi_id_i,
  input  logic [VW-1:0]  eoi_vec_i,
  input  logic           rs_valid_i,
  input  logic [IDW-1:0] rs_id_i,
  input  logic [VW-1:0]  cfg_vec_i,
  input  logic [N-1:0]   proc_pend_i,
  output logic [CW-1:0]  pend_cnt_o,
  output logic [N-1:0]   map_o
);
  tat_op_e       op;
  logic [N-1:0]  hit_v;
  logic [N-1:0]  diff_v;
  logic [N-1:0]  pend_sh;
  logic          rs_pend;
  logic          eoi_hit;
  logic          rs_diff;
  logic          cnt_zero;
  logic          dlv_ok;
  logic          take_one;
  logic          underflow;
  logic          rebuild_all;
  logic          err_q;

  tat_opsel u_opsel (
    .clr_i       (clr_i),
    .rebuild_i   (rebuild_i),
    .dlv_valid_i (dlv_valid_i),
    .eoi_valid_i (eoi_valid_i),
    .rs_valid_i  (rs_valid_i),
    .op_o        (op)
  );

  assign pend_sh   = proc_pend_i >> rs_id_i;
  assign rs_pend   = pend_sh[0];
  assign eoi_hit   = |hit_v;
  assign rs_diff   = |diff_v;
  assign cnt_zero  = (pend_cnt_o == '0);
  assign dlv_ok    = (op == OP_DLV) && cnt_zero;
  assign take_one  = eoi_hit || (rs_diff && !rs_pend);
  assign underflow = cnt_zero && take_one;
  assign rebuild_all = (op == OP_REBUILD) || underflow;

  for (genvar g = 0; g < N; g++) begin : g_slot
    tat_slot #(.VW(VW), .IDW(IDW), .IDX(g)) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_i          (op),
      .rebuild_all_i (rebuild_all),
      .dlv_ok_i      (dlv_ok),
      .dlv_bit_i     (dlv_map_i[g]),
      .dlv_vec_i     (dlv_vec_i),
      .eoi_id_i      (eoi_id_i),
      .eoi_vec_i     (eoi_vec_i),
      .rs_id_i       (rs_id_i),
      .cfg_vec_i     (cfg_vec_i),
      .pend_bit_i    (proc_pend_i[g]),
      .bit_o         (map_o[g]),
      .eoi_hit_o     (hit_v[g]),
      .rs_diff_o     (diff_v[g])
    );
  end

  tat_count #(.N(N), .CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (op == OP_CLR),
    .rebuild_i  (rebuild_all),
    .pend_vec_i (proc_pend_i),
    .load_i     (dlv_ok),
    .load_val_i (dlv_cnt_i),
    .inc_i      (rs_diff && rs_pend),
    .dec_i      (take_one),
    .cnt_o      (pend_cnt_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (op == OP_DLV) && !cnt_zero;
  end

  assign dlv_err_o   = err_q;
  assign coalesced_o = line_rise_i && !cnt_zero;
endmodule

// File: rtl/tat_chk.sv
module tat_chk #(
  parameter int N   = 8,
  parameter int CW  = 4,
  parameter int IDW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_i,
  input logic           rebuild_i,
  input logic           line_rise_i,
  input logic           dlv_valid_i,
  input logic           eoi_valid_i,
  input logic [IDW-1:0] eoi_id_i,
  input logic [N-1:0]   proc_pend_i,
  input logic           coalesced_o,
  input logic           dlv_err_o,
  input logic [CW-1:0]  pend_cnt_o,
  input logic [N-1:0]   map_o
);
  logic [N-1:0] eoi_sel_bits;
  assign eoi_sel_bits = map_o >> eoi_id_i;

  a_r1_coalesced_set: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise_i && pend_cnt_o != '0) |-> coalesced_o);

  a_r1_coalesced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_rise_i || pend_cnt_o == '0) |-> !coalesced_o);

  a_r4_refused_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_i && !clr_i && !rebuild_i && pend_cnt_o != '0)
      |=> (dlv_err_o && $stable(map_o) && $stable(pend_cnt_o)));

  a_r6_eoi_unrecorded: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid_i && !clr_i && !rebuild_i && !dlv_valid_i && !eoi_sel_bits[0])
      |=> ($stable(map_o) && $stable(pend_cnt_o)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pend_cnt_o == '0 && map_o == '0));

  a_r8_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
    (rebuild_i && !clr_i)
      |=> (map_o == $past(proc_pend_i) && 32'(pend_cnt_o) == $countones($past(proc_pend_i))));
endmodule

bind tick_ack_tracker tat_chk #(.N(N), .CW(CW), .IDW(IDW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .rebuild_i   (rebuild_i),
  .line_rise_i (line_rise_i),
  .dlv_valid_i (dlv_valid_i),
  .eoi_valid_i (eoi_valid_i),
  .eoi_id_i    (eoi_id_i),
  .proc_pend_i (proc_pend_i),
  .coalesced_o (coalesced_o),
  .dlv_err_o   (dlv_err_o),
  .pend_cnt_o  (pend_cnt_o),
  .map_o       (map_o)
);

// File: tb/tick_ack_tracker_tb_top.sv
`timescale 1ns/1ps
module tick_ack_tracker_tb_top;
  localparam int N   = 8;
  localparam int VW  = 8;
  localparam int CW  = 4;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 0, rebuild_i = 0, line_rise_i = 0;
  logic dlv_valid_i = 0, eoi_valid_i = 0, rs_valid_i = 0;
  logic [N-1:0]   dlv_map_i = '0, proc_pend_i = '0;
  logic [VW-1:0]  dlv_vec_i = '0, eoi_vec_i = '0, cfg_vec_i = '0;
  logic [CW:0]    dlv_cnt_i = '0;
  logic [IDW-1:0] eoi_id_i = '0, rs_id_i = '0;
  logic           coalesced_o, dlv_err_o;
  logic [CW-1:0]  pend_cnt_o;
  logic [N-1:0]   map_o;

  always #2.5 clk = ~clk;

  tick_ack_tracker #(.N(N), .VW(VW)) dut_i (.*);

  typedef struct {
    logic [CW-1:0] cnt;
    logic [N-1:0]  map;
    logic          err;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0]  m_map = '0;
  logic [VW-1:0] m_vec [N];
  int            m_cnt = 0;

  task automatic m_rebuild(input logic [N-1:0] pend, input logic [VW-1:0] cfg);
    m_map = pend;
    m_cnt = 0;
    for (int i = 0; i < N; i++) if (pend[i]) begin m_vec[i] = cfg; m_cnt++; end
  endtask

  // driver: drive one cycle of events, predict and queue the result
  task automatic apply(input string tag,
                       input bit clr, input bit rb, input bit lr,
                       input bit dv, input logic [N-1:0] dm, input logic [VW-1:0] dvec, input int dc,
                       input bit ev, input int eid, input logic [VW-1:0] evec,
                       input bit rv, input int rid, input logic [VW-1:0] cfg,
                       input logic [N-1:0] pend);
    exp_t e;
    bit exp_co;
    @(negedge clk);
    clr_i = clr; rebuild_i = rb; line_rise_i = lr;
    dlv_valid_i = dv; dlv_map_i = dm; dlv_vec_i = dvec; dlv_cnt_i = (CW+1)'(dc);
    eoi_valid_i = ev; eoi_id_i = IDW'(eid); eoi_vec_i = evec;
    rs_valid_i = rv; rs_id_i = IDW'(rid); cfg_vec_i = cfg; proc_pend_i = pend;
    exp_co = lr && (m_cnt != 0);
    e.err = 1'b0;
    if (clr) begin
      m_map = '0; m_cnt = 0;
    end else if (rb) begin
      m_rebuild(pend, cfg);
    end else if (dv) begin
      if (m_cnt == 0) begin
        m_map = dm;
        for (int i = 0; i < N; i++) if (dm[i]) m_vec[i] = dvec;
        m_cnt = (dc < 0) ? 0 : dc;
      end else e.err = 1'b1;
    end else if (ev) begin
      if (m_map[eid] && m_vec[eid] == evec) begin
        if (m_cnt == 0) m_rebuild(pend, cfg);
        else begin m_map[eid] = 1'b0; m_cnt--; end
      end
    end else if (rv) begin
      if (pend[rid] != m_map[rid]) begin
        if (pend[rid]) begin m_map[rid] = 1'b1; m_vec[rid] = cfg; m_cnt++; end
        else if (m_cnt == 0) m_rebuild(pend, cfg);
        else begin m_map[rid] = 1'b0; m_cnt--; end
      end
    end
    e.cnt = CW'(m_cnt); e.map = m_map; e.tag = tag;
    exp_q.push_back(e);
    #1;
    checks++;
    if (coalesced_o !== exp_co) begin
      fails++;
      $display("FAIL %s R1 coalesced_o actual=%0b expected=%0b", tag, coalesced_o, exp_co);
    end
  endtask

  task automatic idle(input string tag);
    apply(tag, 0,0,0, 0,'0,'0,0, 0,0,'0, 0,0,'0, proc_pend_i);
  endtask

  // monitor: compare the registered outputs after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (pend_cnt_o !== e.cnt || map_o !== e.map || dlv_err_o !== e.err) begin
          fails++;
          $display("FAIL %s cnt/map/err actual=%0d/%h/%0b expected=%0d/%h/%0b",
                   e.tag, pend_cnt_o, map_o, dlv_err_o, e.cnt, e.map, e.err);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_vec[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (pend_cnt_o !== '0 || map_o !== '0 || dlv_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R7 reset state actual=%0d/%h/%0b expected=0/00/0", pend_cnt_o, map_o, dlv_err_o);
    end
    // R1: edge with nothing owed is not coalesced
    apply("R1 idle edge", 0,0,1, 0,'0,'0,0, 0,0,'0, 0,0,'0, '0);
    // R2: delivery to 0,1,3 with vector 31
    apply("R2 deliver", 0,0,0, 1,8'h0B,8'h31,3, 0,0,'0, 0,0,'0, '0);
    apply("R1 edge while owed", 0,0,1, 0,'0,'0,0, 0,0,'0, 0,0,'0, '0);
    // R4: second delivery refused
    apply("R4 refused", 0,0,0, 1,8'hF0,8'h77,4, 0,0,'0, 0,0,'0, '0);
    idle("R4 error pulse ends");
    // R5 / R6
    apply("R5 eoi hit", 0,0,0, 0,'0,'0,0, 1,1,8'h31, 0,0,'0, '0);
    apply("R6 eoi bit clear", 0,0,0, 0,'0,'0,0, 1,1,8'h31, 0,0,'0, '0);
    apply("R6 eoi wrong vector", 0,0,0, 0,'0,'0,0, 1,0,8'h32, 0,0,'0, '0);
    apply("R6 eoi unrecorded", 0,0,0, 0,'0,'0,0, 1,6,8'h31, 0,0,'0, '0);
    apply("R5 eoi hit 0", 0,0,0, 0,'0,'0,0, 1,0,8'h31, 0,0,'0, '0);
    apply("R5 eoi hit 3", 0,0,0, 0,'0,'0,0, 1,3,8'h31, 0,0,'0, '0);
    // R3: failed delivery clamps to zero
    apply("R3 negative count", 0,0,0, 1,8'h04,8'h40,-1, 0,0,'0, 0,0,'0, '0);
    // R9: retire with count zero rebuilds from live status
    apply("R9 eoi underflow", 0,0,0, 0,'0,'0,0, 1,2,8'h40, 0,0,8'h55, 8'h21);
    // R10 resync
    apply("R10 resync agree", 0,0,0, 0,'0,'0,0, 0,0,'0, 1,5,8'h55, 8'h21);
    apply("R10 resync set", 0,0,0, 0,'0,'0,0, 0,0,'0, 1,4,8'h55, 8'h31);
    apply("R8 rebuilt vector", 0,0,0, 0,'0,'0,0, 1,4,8'h55, 0,0,8'h55, 8'h31);
    apply("R10 resync clear", 0,0,0, 0,'0,'0,0, 0,0,'0, 1,5,8'h55, 8'h01);
    // R11 priority collisions
    apply("R11 clear beats eoi", 1,0,0, 0,'0,'0,0, 1,0,8'h55, 0,0,8'h55, 8'h01);
    apply("R11 rebuild beats delivery", 0,1,0, 1,8'h80,8'h11,1, 0,0,'0, 0,0,8'h66, 8'h0E);
    apply("R11 delivery beats eoi", 0,0,0, 1,8'h80,8'h11,1, 1,1,8'h66, 0,0,8'h66, 8'h0E);
    apply("R11 eoi beats resync", 0,0,0, 0,'0,'0,0, 1,2,8'h66, 1,7,8'h66, 8'hFE);
    apply("R8 rebuild", 0,1,0, 0,'0,'0,0, 0,0,'0, 0,0,8'h12, 8'hC3);
    apply("R7 clear", 1,0,0, 0,'0,'0,0, 0,0,'0, 0,0,'0, '0);
    // R11 mixed sequence against the model
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 19);
      apply("R11 mix",
            sel == 0, sel == 1, $urandom_range(0,1) == 1,
            sel >= 2 && sel <= 5, N'($urandom), 8'($urandom_range(1,3)), $urandom_range(0,8) - 3,
            sel >= 4 && sel <= 12, $urandom_range(0,N-1), 8'($urandom_range(1,3)),
            sel >= 10, $urandom_range(0,N-1), 8'($urandom_range(1,3)),
            N'($urandom));
    end
    idle("final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule